// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block watches a host processor that must write a feed register at regular intervals. Software sets it up through a small write-only register port with three registers: configuration, timeout and feed. An internal prescaler turns the system clock into a fixed tick of 0.1 ms, and every interval is measured in these ticks. The timeout register sets a short interval and a long interval. The short interval is the base unit of 11 ticks shifted left by a select value. The long interval is the short one times 2, 4, 8 or 16.

There are two supervision modes. In window mode a feed that arrives too soon after the last restart is an error, and so is a missing feed. In slow mode only the missing feed is an error. Either fault sets a sticky interrupt output. If the configuration asks for it, the fault also drives a reset output for a fixed number of clock cycles. Software clears the interrupt through the feed register. Any enable encoding other than plain feed supervision leaves the block idle.

Top module: `wdt_win`

## Requirements
- R1: After reset both outputs are low, the configuration register holds 0 (disabled) and the timeout register holds 0.
- R2: Register address 1 is the timeout register, with the short select in bits 6:4 and the ratio in bits 1:0. The short interval is S = BASE_TICKS << select ticks. The long interval is L = S << (ratio + 1) ticks, which makes ratios 0..3 equal to 2x, 4x, 8x and 16x. One tick lasts CLK_PER_TICK clock cycles.
- R3: Register address 0 is configuration; bits 1:0 = 01 enables supervision. While enabled, a missing feed is a fault. The interrupt rises at the edge L·CLK_PER_TICK+2 cycles after the edge that captured the enable write. After a fault with no feed in between, the next one follows L·CLK_PER_TICK+1 cycles later.
- R4: When configuration bit 2 is 0 (window mode), a feed is early if it is captured while fewer than S full ticks have passed since the last restart. An early feed is a fault, and the interrupt rises at the edge that captures it. After the enable write this means any feed up to S·CLK_PER_TICK+1 cycles later. After an accepted feed it means any feed up to S·CLK_PER_TICK cycles later.
- R5: When configuration bit 2 is 1 (slow mode), a feed is never a fault, however early it arrives.
- R6: A feed is a write to address 2 with bit 0 set. An accepted feed restarts the interval at its capture edge, so the next late fault comes L·CLK_PER_TICK+1 cycles later.
- R7: With enable bits 00, 10 or 11 the block raises no fault, and feeds have no effect.
- R8: The interrupt stays high until a write to address 2 with bit 1 set. If a fault occurs in the same cycle as that write, the fault wins.
- R9: When configuration bit 3 is 1, a fault also drives the reset output high for exactly RST_CYCLES cycles, starting at the fault edge. During the pulse, feeds and faults are ignored. Counting restarts at the edge where the pulse ends.
- R10: A change from disabled to enabled starts the interval from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 2 | Register address: 0 configuration, 1 timeout, 2 feed |
| wr_data | input | DATA_W | Write data |
| wd_irq | output | 1 | Sticky fault interrupt |
| wd_rst | output | 1 | Reset pulse on fault when the reset action is selected |

## Verification
The checker watches the following rules on every cycle:
- the interrupt rises only while supervision is running;
- the interrupt stays high until a clear, and a clear with no fault in the same cycle drops it;
- the reset output rises only after a fault with the reset action selected;
- every reset pulse is exactly RST_CYCLES cycles long;
- no fault occurs during a pulse.

Only the bench scenarios can show the cycle at which a late fault fires for a given select and ratio, or where the boundary between an early and an accepted feed lies. They also show that a feed restarts the interval and that a feed during a pulse is ignored. The same holds for the idle enable encodings.

// File: rtl/wdt_win_pkg.sv
package wdt_win_pkg;

   typedef enum logic [1:0] {
      REG_CFG  = 2'd0,
      REG_TMO  = 2'd1,
      REG_FEED = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      EN_OFF  = 2'b00,
      EN_FEED = 2'b01,
      EN_QA   = 2'b10,
      EN_RSVD = 2'b11
   } en_mode_e;

   // packed from bit 3 down to bit 0 of the configuration register
   typedef struct packed {
      logic     act_rst;
      logic     slow;
      en_mode_e en;
   } cfg_t;

   localparam int CFG_W         = 4;
   localparam int TMO_SEL_LSB   = 4;
   localparam int TMO_RATIO_LSB = 0;
   localparam int FEED_BIT      = 0;
   localparam int IRQ_CLR_BIT   = 1;

endpackage

// File: rtl/wdt_win_prescale.sv
module wdt_win_prescale #(
   parameter int CLK_PER_TICK = 20000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   output logic tick_o
);

   generate
      if (CLK_PER_TICK == 1) begin : g_bypass
         logic unused_bypass;
         assign unused_bypass = clk ^ rst_n ^ clear_i;
         assign tick_o = 1'b1;
      end else begin : g_count
         localparam int PRE_W = $clog2(CLK_PER_TICK);
         logic [PRE_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (clear_i || tick_o) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + PRE_W'(1);
            end
         end

         assign tick_o = (cnt_q == PRE_W'(CLK_PER_TICK - 1));
      end
   endgenerate

endmodule

// File: rtl/wdt_win_timer.sv
module wdt_win_timer #(
   parameter int BASE_TICKS = 11,
   parameter int SEL_W      = 3,
   parameter int RATIO_W    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear_i,
   input  logic               tick_i,
   input  logic               run_i,
   input  logic               feed_i,
   input  logic               slow_i,
   input  logic [SEL_W-1:0]   sel_i,
   input  logic [RATIO_W-1:0] ratio_i,
   output logic               early_o,
   output logic               late_o
);

   localparam int MAX_SEL_SH   = (1 << SEL_W) - 1;
   localparam int MAX_RATIO_SH = (1 << RATIO_W);
   localparam longint LONG_MAX = longint'(BASE_TICKS) << (MAX_SEL_SH + MAX_RATIO_SH);
   localparam int CNT_W        = $clog2(LONG_MAX + 1);

   logic [CNT_W-1:0] elapsed_q;
   logic [CNT_W-1:0] short_t;
   logic [CNT_W-1:0] long_t;

   always_comb begin
      short_t = CNT_W'(BASE_TICKS) << sel_i;
      long_t  = (short_t << ratio_i) << 1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elapsed_q <= '0;
      end else if (clear_i) begin
         elapsed_q <= '0;
      end else if (tick_i) begin
         elapsed_q <= elapsed_q + CNT_W'(1);
      end
   end

   assign early_o = run_i && feed_i && !slow_i && (elapsed_q < short_t);
   assign late_o  = run_i && (elapsed_q >= long_t);

endmodule

// File: rtl/wdt_win_regs.sv
module wdt_win_regs
   import wdt_win_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int SEL_W   = 3,
   parameter int RATIO_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output cfg_t               cfg_o,
   output logic [SEL_W-1:0]   sel_o,
   output logic [RATIO_W-1:0] ratio_o,
   output logic               feed_wr_o,
   output logic               irq_clr_o
);

   logic unused_data;
   assign unused_data = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_o   <= '0;
         sel_o   <= '0;
         ratio_o <= '0;
      end else if (wr_en) begin
         case (reg_sel_e'(wr_addr))
            REG_CFG: cfg_o <= cfg_t'(wr_data[CFG_W-1:0]);
            REG_TMO: begin
               sel_o   <= wr_data[TMO_SEL_LSB +: SEL_W];
               ratio_o <= wr_data[TMO_RATIO_LSB +: RATIO_W];
            end
            default: ;
         endcase
      end
   end

   assign feed_wr_o = wr_en && (wr_addr == REG_FEED) && wr_data[FEED_BIT];
   assign irq_clr_o = wr_en && (wr_addr == REG_FEED) && wr_data[IRQ_CLR_BIT];

endmodule

// File: rtl/wdt_win.sv
module wdt_win
   import wdt_win_pkg::*;
#(
   parameter int CLK_PER_TICK = 20000,
   parameter int BASE_TICKS   = 11,
   parameter int SEL_W        = 3,
   parameter int RATIO_W      = 2,
   parameter int RST_CYCLES   = 32,
   parameter int DATA_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wd_irq,
   output logic              wd_rst
);

   localparam int PULSE_W = $clog2(RST_CYCLES + 1);

   initial begin : param_chk
      if (CLK_PER_TICK < 1)  $error("CLK_PER_TICK must be at least 1");
      if (BASE_TICKS < 1)    $error("BASE_TICKS must be at least 1");
      if (RST_CYCLES < 1)    $error("RST_CYCLES must be at least 1");
      if (TMO_SEL_LSB + SEL_W > DATA_W) $error("select field does not fit DATA_W");
      if (RATIO_W > TMO_SEL_LSB)        $error("ratio field overlaps select field");
      if (DATA_W < CFG_W)               $error("DATA_W too narrow for configuration");
   end

   cfg_t               cfg;
   logic [SEL_W-1:0]   sel;
   logic [RATIO_W-1:0] ratio;
   logic               feed_wr;
   logic               irq_clr;
   logic               active;
   logic               active_q;
   logic               enable_edge;
   logic               hold;
   logic               run;
   logic               tick;
   logic               early;
   logic               late;
   logic               fault;
   logic               clear;
   logic [PULSE_W-1:0] pulse_q;
   logic               irq_q;

   wdt_win_regs #(
      .DATA_W  (DATA_W),
      .SEL_W   (SEL_W),
      .RATIO_W (RATIO_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .cfg_o     (cfg),
      .sel_o     (sel),
      .ratio_o   (ratio),
      .feed_wr_o (feed_wr),
      .irq_clr_o (irq_clr)
   );

   assign active      = (cfg.en == EN_FEED);
   assign enable_edge = active && !active_q;
   assign hold        = (pulse_q != '0);
   assign run         = active && !hold;
   assign fault       = early || late;
   assign clear       = !run || enable_edge || feed_wr || fault;

   wdt_win_prescale #(
      .CLK_PER_TICK (CLK_PER_TICK)
   ) u_prescale (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear),
      .tick_o  (tick)
   );

   wdt_win_timer #(
      .BASE_TICKS (BASE_TICKS),
      .SEL_W      (SEL_W),
      .RATIO_W    (RATIO_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear),
      .tick_i  (tick),
      .run_i   (run),
      .feed_i  (feed_wr),
      .slow_i  (cfg.slow),
      .sel_i   (sel),
      .ratio_i (ratio),
      .early_o (early),
      .late_o  (late)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         irq_q    <= 1'b0;
         pulse_q  <= '0;
      end else begin
         active_q <= active;
         if (fault) begin
            irq_q <= 1'b1;
         end else if (irq_clr) begin
            irq_q <= 1'b0;
         end
         if (fault && cfg.act_rst) begin
            pulse_q <= PULSE_W'(RST_CYCLES);
         end else if (hold) begin
            pulse_q <= pulse_q - PULSE_W'(1);
         end
      end
   end

   assign wd_irq = irq_q;
   assign wd_rst = hold;

endmodule

// File: rtl/wdt_win_chk.sv
module wdt_win_chk #(
   parameter int RST_CYCLES = 32
) (
   input logic clk,
   input logic rst_n,
   input logic run,
   input logic fault,
   input logic irq_clr,
   input logic act_rst,
   input logic wd_irq,
   input logic wd_rst
);

   localparam int HC_W = $clog2(RST_CYCLES + 2);
   logic [HC_W-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= '0;
      end else if (wd_rst) begin
         hi_cnt <= hi_cnt + HC_W'(1);
      end else begin
         hi_cnt <= '0;
      end
   end

   // R7
   irq_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_irq) |-> $past(run));

   // R8
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_irq && !irq_clr) |=> wd_irq);

   // R8
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !fault) |=> !wd_irq);

   // R9
   rst_needs_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_rst) |-> $past(act_rst && fault));

   // R9
   rst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wd_rst) |-> (hi_cnt == HC_W'(RST_CYCLES)));

   // R9
   no_fault_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst |-> !fault);

endmodule

bind wdt_win wdt_win_chk #(
   .RST_CYCLES (RST_CYCLES)
) u_wdt_win_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .run     (run),
   .fault   (fault),
   .irq_clr (irq_clr),
   .act_rst (cfg.act_rst),
   .wd_irq  (wd_irq),
   .wd_rst  (wd_rst)
);

// File: tb/wdt_win_bench.sv
`timescale 1ns/100ps
module wdt_win_bench;

   localparam int CPT  = 2;
   localparam int BASE = 11;
   localparam int RSTC = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       wd_irq;
   logic       wd_rst;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int t_wr  = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wdt_win #(
      .CLK_PER_TICK (CPT),
      .BASE_TICKS   (BASE),
      .RST_CYCLES   (RSTC)
   ) u_wdt_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .wd_irq  (wd_irq),
      .wd_rst  (wd_rst)
   );

   function automatic int short_cyc(int sel);
      return (BASE << sel) * CPT;
   endfunction

   function automatic int long_cyc(int sel, int ratio);
      return ((BASE << sel) << (ratio + 1)) * CPT;
   endfunction

   function automatic logic [7:0] cfg_byte(bit act, bit slow, int en);
      return {4'd0, act, slow, 2'(en)};
   endfunction

   task automatic check(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
      end
   endtask

   task automatic go_edge(int n);
      while (cyc < n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic wr_at(int edge_n, int addr, int data);
      go_edge(edge_n - 1);
      check("R2 write schedule", cyc, edge_n - 1);
      wr_en   = 1'b1;
      wr_addr = 2'(addr);
      wr_data = 8'(data);
      @(posedge clk);
      #1;
      t_wr    = cyc;
      wr_en   = 1'b0;
      wr_data = 8'd0;
   endtask

   task automatic wr(int addr, int data);
      wr_at(cyc + 1, addr, data);
   endtask

   task automatic quiet();
      wr(0, 0);
      wr(2, 2);
      go_edge(cyc + RSTC + 2);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired: actual=%0d expected=0", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int t0;
      int te;
      int tf;
      void'($urandom(32'h5eed_1234));
      repeat (4) @(posedge clk);
      #1;
      // R1: reset state
      check("R1 irq after reset", wd_irq, 0);
      check("R1 rst after reset", wd_rst, 0);
      rst_n = 1'b1;
      go_edge(cyc + 2);

      // R7: disabled, feeds ignored, no fault
      wr(1, 8'h00);
      wr(0, cfg_byte(0, 0, 0));
      wr(2, 1);
      go_edge(cyc + 3 * long_cyc(0, 0));
      check("R7 disabled no fault", wd_irq, 0);
      wr(0, cfg_byte(1, 0, 2));
      go_edge(cyc + 3 * long_cyc(0, 0));
      check("R7 encoding 10 no fault", wd_irq + wd_rst, 0);
      wr(0, cfg_byte(1, 0, 3));
      wr(2, 1);
      go_edge(cyc + 3 * long_cyc(0, 0));
      check("R7 encoding 11 no fault", wd_irq + wd_rst, 0);
      quiet();

      // R3 / R10: late fault timing from enable, slow mode, irq action
      wr(0, cfg_byte(0, 1, 1));
      t0 = t_wr;
      te = t0 + long_cyc(0, 0) + 2;
      go_edge(te - 1);
      check("R3 R10 irq before long interval", wd_irq, 0);
      go_edge(te);
      check("R3 irq at long interval", wd_irq, 1);
      check("R9 no reset pulse with irq action", wd_rst, 0);

      // R8: sticky, clear, fault wins over clear
      go_edge(te + 50);
      check("R8 irq sticky", wd_irq, 1);
      wr(2, 2);
      check("R8 irq cleared", wd_irq, 0);
      wr_at(te + 2 * (long_cyc(0, 0) + 1), 2, 2);
      check("R8 fault beats clear", wd_irq, 1);
      wr(2, 2);
      check("R8 irq cleared again", wd_irq, 0);
      quiet();

      // R4: window mode early feed at the boundary
      wr(0, cfg_byte(0, 0, 1));
      t0 = t_wr;
      wr_at(t0 + short_cyc(0) + 1, 2, 1);
      check("R4 early feed fault", wd_irq, 1);
      quiet();
      wr(0, cfg_byte(0, 0, 1));
      t0 = t_wr;
      wr_at(t0 + short_cyc(0) + 2, 2, 1);
      tf = t_wr;
      check("R4 feed on window edge accepted", wd_irq, 0);
      // R6: feed restarts the interval
      go_edge(tf + long_cyc(0, 0));
      check("R6 no fault before restarted interval", wd_irq, 0);
      go_edge(tf + long_cyc(0, 0) + 1);
      check("R6 fault after restarted interval", wd_irq, 1);
      quiet();

      // R4: early feed after an accepted feed
      wr(0, cfg_byte(0, 0, 1));
      wr_at(t_wr + 30, 2, 1);
      tf = t_wr;
      wr_at(tf + short_cyc(0), 2, 1);
      check("R4 early second feed fault", wd_irq, 1);
      quiet();

      // R5: slow mode early feed is fine
      wr(0, cfg_byte(0, 1, 1));
      wr_at(t_wr + 2, 2, 1);
      tf = t_wr;
      check("R5 early feed in slow mode", wd_irq, 0);
      go_edge(tf + long_cyc(0, 0));
      check("R5 R6 no fault before interval", wd_irq, 0);
      go_edge(tf + long_cyc(0, 0) + 1);
      check("R5 R6 fault after interval", wd_irq, 1);
      quiet();

      // R6: periodic feeds inside the window keep it quiet
      wr(0, cfg_byte(0, 0, 1));
      for (int i = 0; i < 6; i++) begin
         wr_at(t_wr + 30, 2, 1);
      end
      go_edge(t_wr + 40);
      check("R6 keepalive no fault", wd_irq, 0);
      quiet();

      // R9: reset action pulse, feed during pulse ignored
      wr(0, cfg_byte(1, 1, 1));
      t0 = t_wr;
      te = t0 + long_cyc(0, 0) + 2;
      go_edge(te - 1);
      check("R9 rst low before fault", wd_rst, 0);
      go_edge(te);
      check("R9 rst high at fault", wd_rst, 1);
      check("R9 irq raised with reset action", wd_irq, 1);
      wr_at(te + 2, 2, 1);
      go_edge(te + RSTC - 1);
      check("R9 rst high at last pulse cycle", wd_rst, 1);
      go_edge(te + RSTC);
      check("R9 rst low after pulse", wd_rst, 0);
      go_edge(te + RSTC + long_cyc(0, 0));
      check("R9 no second pulse early", wd_rst, 0);
      go_edge(te + RSTC + long_cyc(0, 0) + 1);
      check("R9 second pulse after restart", wd_rst, 1);
      quiet();

      // R2: largest select and ratio
      wr(1, 8'h73);
      wr(0, cfg_byte(0, 1, 1));
      t0 = t_wr;
      te = t0 + long_cyc(7, 3) + 2;
      go_edge(te - 1);
      check("R2 max interval not yet", wd_irq, 0);
      go_edge(te);
      check("R2 max interval fault", wd_irq, 1);
      quiet();

      // R2 R4 R5: random select, ratio, mode and feed offset
      for (int it = 0; it < 10; it++) begin
         int sel;
         int ratio;
         int k;
         bit slow;
         bit early;
         sel   = int'($urandom % 4);
         ratio = int'($urandom % 4);
         slow  = 1'($urandom % 2);
         k     = 1 + int'($urandom % 32'(long_cyc(sel, ratio)));
         if (it == 0) k = short_cyc(sel) + 1;
         if (it == 1) k = short_cyc(sel) + 2;
         early = !slow && (k <= short_cyc(sel) + 1);
         wr(1, (sel << 4) | ratio);
         wr(0, cfg_byte(0, slow, 1));
         t0 = t_wr;
         wr_at(t0 + k, 2, 1);
         tf = t_wr;
         check("R4 R5 random feed outcome", wd_irq, int'(early));
         if (!early) begin
            go_edge(tf + long_cyc(sel, ratio));
            check("R2 random late not yet", wd_irq, 0);
            go_edge(tf + long_cyc(sel, ratio) + 1);
            check("R2 random late fault", wd_irq, 1);
         end
         quiet();
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule